// File: doc/BRIEF.md
# Network Controller Event Status and Mask Registers

This block is the byte-wide host register set that collects event notifications from a network controller's frame engine. Transmit and receive events each land in a sticky status register; each direction also has an interrupt enable register. The host reads a status register to see which events occurred. It clears the events it has handled by writing ones to the same address. A read and a write to one address therefore mean different things.

Each direction produces an active-low interrupt indicator. The indicator is low while any sticky status bit is pending and its enable bit is set. A read-only summary register shows both indicators. A separate control register holds the link core in reset. The frame engine that produces the event pulses and any interrupt controller that consumes the indicators are outside this block. Register reads are combinational from the address; writes take effect at the clock edge.

Top module: `net_evt_regs`

## Requirements
- R1: After reset all status, enable and control registers are 0. Both interrupt outputs are high and core_rst_o is low. The summary register at 0x13 reads 0x03.
- R2: Transmit status is at offset 0x00. A pulse on tx_evt_i bit 7, 5, 4, 3, 2, 1 or 0 sets the same status bit at the next edge, and the bit stays set until the host clears it.
- R3: Receive status is at offset 0x02. A pulse on rx_evt_i bit 7, 4, 3, 2, 1 or 0 sets the same sticky bit. Bits 6 and 5 always read 0 and are never set.
- R4: A write to a status offset clears every bit written as 1 and leaves the bits written as 0 unchanged.
- R5: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: Transmit status bit 6 reads the live carrier_i level. It is not stored, a write to it has no effect, and tx_evt_i bit 6 is ignored.
- R7: The transmit enable register at 0x01 and the receive enable register at 0x03 are read/write. Transmit enable bits 6 and 0 always read 0. Receive enable bits 6 and 5 always read 0.
- R8: tx_irq_no is low exactly when the stored transmit status AND the transmit enable is nonzero; rx_irq_no works the same way. Offset 0x13 reads {6'b0, rx_irq_no, tx_irq_no}, and writes to 0x13 have no effect.
- R9: Bit 7 of the control register at 0x06 drives core_rst_o and reads back. The other bits of that register read 0.
- R10: Unmapped offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | ADDR_W | Register offset |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data for addr_i |
| tx_evt_i | input | 8 | Transmit event pulses |
| rx_evt_i | input | 8 | Receive event pulses |
| carrier_i | input | 1 | Live carrier level |
| tx_irq_no | output | 1 | Transmit interrupt, active low |
| rx_irq_no | output | 1 | Receive interrupt, active low |
| core_rst_o | output | 1 | Holds link core in reset |

## Verification
The checker watches these properties on every cycle:
- an event pulse always leaves its sticky bit set on the next cycle;
- a clearing write removes the written bits unless an event re-sets them;
- the reserved receive bits and the forced-zero enable bits stay 0;
- an interrupt only asserts after an event or a write;
- the control bit changes only on a write to its offset.

The bench's scenarios cover the rest. They check the full read-back of every offset under mixed event and write traffic. They also cover the live carrier bit, a set and a clear colliding on one bit, and writes to the summary and unmapped offsets leaving every register unchanged.

// File: rtl/net_evt_pkg.sv
package net_evt_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned OFF_TX_ST  = 'h00;
  localparam int unsigned OFF_TX_EN  = 'h01;
  localparam int unsigned OFF_RX_ST  = 'h02;
  localparam int unsigned OFF_RX_EN  = 'h03;
  localparam int unsigned OFF_CTRL   = 'h06;
  localparam int unsigned OFF_SUMM   = 'h13;
  // bits that hold sticky state / writable enables
  localparam logic [DW-1:0] TX_STICKY = 8'hBF;
  localparam logic [DW-1:0] RX_STICKY = 8'h9F;
  localparam logic [DW-1:0] TX_EN_WR  = 8'hBE;
  localparam logic [DW-1:0] RX_EN_WR  = 8'h9F;
  localparam logic [DW-1:0] CTRL_WR   = 8'h80;
  localparam int unsigned   TX_CARRIER_BIT = 6;
endpackage

// File: rtl/net_evt_status.sv
module net_evt_status #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] STICKY = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] st_o
);
  logic [W-1:0] st_q, clr_m;

  assign clr_m = clr_en_i ? clr_i : '0;

  // set applied after clear: a coincident event is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= ((st_q & ~clr_m) | set_i) & STICKY;
  end

  assign st_o = st_q;
endmodule

// File: rtl/net_evt_reg.sv
module net_evt_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (we_i) q_q <= d_i & WMASK;
  end

  assign q_o = q_q;
endmodule

// File: rtl/net_evt_regs.sv
module net_evt_regs
  import net_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     tx_evt_i,
  input  logic [DW-1:0]     rx_evt_i,
  input  logic              carrier_i,
  output logic              tx_irq_no,
  output logic              rx_irq_no,
  output logic              core_rst_o
);
  localparam logic [ADDR_W-1:0] A_TX_ST = ADDR_W'(OFF_TX_ST);
  localparam logic [ADDR_W-1:0] A_TX_EN = ADDR_W'(OFF_TX_EN);
  localparam logic [ADDR_W-1:0] A_RX_ST = ADDR_W'(OFF_RX_ST);
  localparam logic [ADDR_W-1:0] A_RX_EN = ADDR_W'(OFF_RX_EN);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_SUMM  = ADDR_W'(OFF_SUMM);

  logic [DW-1:0] tx_st, rx_st, tx_mask, rx_mask, ctrl;
  logic [DW-1:0] tx_view;

  net_evt_status #(.W(DW), .STICKY(TX_STICKY)) u_tx_st (
    .clk_i, .rst_ni,
    .clr_en_i (wr_en_i && addr_i == A_TX_ST),
    .clr_i    (wdata_i),
    .set_i    (tx_evt_i),
    .st_o     (tx_st)
  );

  net_evt_status #(.W(DW), .STICKY(RX_STICKY)) u_rx_st (
    .clk_i, .rst_ni,
    .clr_en_i (wr_en_i && addr_i == A_RX_ST),
    .clr_i    (wdata_i),
    .set_i    (rx_evt_i),
    .st_o     (rx_st)
  );

  net_evt_reg #(.W(DW), .WMASK(TX_EN_WR)) u_tx_en (
    .clk_i, .rst_ni,
    .we_i (wr_en_i && addr_i == A_TX_EN),
    .d_i  (wdata_i),
    .q_o  (tx_mask)
  );

  net_evt_reg #(.W(DW), .WMASK(RX_EN_WR)) u_rx_en (
    .clk_i, .rst_ni,
    .we_i (wr_en_i && addr_i == A_RX_EN),
    .d_i  (wdata_i),
    .q_o  (rx_mask)
  );

  net_evt_reg #(.W(DW), .WMASK(CTRL_WR)) u_ctrl (
    .clk_i, .rst_ni,
    .we_i (wr_en_i && addr_i == A_CTRL),
    .d_i  (wdata_i),
    .q_o  (ctrl)
  );

  always_comb begin
    tx_view = tx_st;
    tx_view[TX_CARRIER_BIT] = carrier_i;
  end

  assign tx_irq_no  = ~|(tx_st & tx_mask);
  assign rx_irq_no  = ~|(rx_st & rx_mask);
  assign core_rst_o = ctrl[DW-1];

  always_comb begin
    unique case (addr_i)
      A_TX_ST: rdata_o = tx_view;
      A_TX_EN: rdata_o = tx_mask;
      A_RX_ST: rdata_o = rx_st;
      A_RX_EN: rdata_o = rx_mask;
      A_CTRL:  rdata_o = ctrl;
      A_SUMM:  rdata_o = {{(DW-2){1'b0}}, rx_irq_no, tx_irq_no};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/net_evt_regs_chk.sv
module net_evt_regs_chk
  import net_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     tx_evt_i,
  input logic [DW-1:0]     rx_evt_i,
  input logic [DW-1:0]     tx_st,
  input logic [DW-1:0]     rx_st,
  input logic [DW-1:0]     tx_mask,
  input logic [DW-1:0]     rx_mask,
  input logic              tx_irq_no,
  input logic              rx_irq_no,
  input logic              core_rst_o
);
  a_r2_tx_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(tx_evt_i & TX_STICKY)) |=> ((tx_st & $past(tx_evt_i & TX_STICKY)) == $past(tx_evt_i & TX_STICKY)));

  a_r3_rx_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(rx_evt_i & RX_STICKY)) |=> ((rx_st & $past(rx_evt_i & RX_STICKY)) == $past(rx_evt_i & RX_STICKY)));

  a_r3_rx_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_st[6:5] == 2'b00);

  a_r4_tx_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFF_TX_ST)) |=> ((tx_st & $past(wdata_i) & ~$past(tx_evt_i)) == '0));

  a_r4_rx_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFF_RX_ST)) |=> ((rx_st & $past(wdata_i) & ~$past(rx_evt_i)) == '0));

  a_r7_en_forced_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_mask[6] == 1'b0 && tx_mask[0] == 1'b0 && rx_mask[6:5] == 2'b00);

  a_r8_tx_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_irq_no) |-> ($past(|tx_evt_i) || $past(wr_en_i)));

  a_r8_rx_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_irq_no) |-> ($past(|rx_evt_i) || $past(wr_en_i)));

  a_r9_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_W'(OFF_CTRL)) |=> $stable(core_rst_o));
endmodule

bind net_evt_regs net_evt_regs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/net_evt_regs_bench.sv
`timescale 1ns/1ps
module net_evt_regs_bench;
  localparam int AW = 5;
  logic clk_i = 0, rst_ni = 0, wr_en_i = 0, carrier_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] wdata_i = '0, tx_evt_i = '0, rx_evt_i = '0, rdata_o;
  logic tx_irq_no, rx_irq_no, core_rst_o;

  int checks = 0, errors = 0;
  logic [7:0] m_tx = 0, m_rx = 0, m_txm = 0, m_rxm = 0, m_ctl = 0;

  always #5 clk_i = ~clk_i;

  net_evt_regs #(.ADDR_W(AW)) u_net_evt_regs (.*);

  function automatic logic [7:0] exp_read(input logic [AW-1:0] a);
    case (a)
      5'h00: exp_read = (m_tx & 8'hBF) | {1'b0, carrier_i, 6'b0};
      5'h01: exp_read = m_txm;
      5'h02: exp_read = m_rx;
      5'h03: exp_read = m_rxm;
      5'h06: exp_read = m_ctl;
      5'h13: exp_read = {6'b0, ~|(m_rx & m_rxm), ~|(m_tx & m_txm)};
      default: exp_read = 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a);
    case (a)
      5'h00: tag_of = "R2";
      5'h01, 5'h03: tag_of = "R7";
      5'h02: tag_of = "R3";
      5'h06: tag_of = "R9";
      5'h13: tag_of = "R8";
      default: tag_of = "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // one clock with given stimulus; model updated at the edge
  task automatic cyc(input logic wr, input logic [AW-1:0] a, input logic [7:0] wd,
                     input logic [7:0] txe, input logic [7:0] rxe);
    @(negedge clk_i);
    wr_en_i = wr; addr_i = a; wdata_i = wd; tx_evt_i = txe; rx_evt_i = rxe;
    @(posedge clk_i);
    if (wr && a == 5'h00) m_tx = m_tx & ~wd;
    if (wr && a == 5'h02) m_rx = m_rx & ~wd;
    m_tx = (m_tx | txe) & 8'hBF;
    m_rx = (m_rx | rxe) & 8'h9F;
    if (wr && a == 5'h01) m_txm = wd & 8'hBE;
    if (wr && a == 5'h03) m_rxm = wd & 8'h9F;
    if (wr && a == 5'h06) m_ctl = wd & 8'h80;
    #1;
    wr_en_i = 0; tx_evt_i = 0; rx_evt_i = 0;
  endtask

  task automatic check_all();
    logic [AW-1:0] offs [7];
    offs = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h06, 5'h13, 5'h0B};
    @(negedge clk_i);
    wr_en_i = 0; tx_evt_i = 0; rx_evt_i = 0;
    for (int i = 0; i < 7; i++) begin
      addr_i = offs[i];
      #0.5;
      chk(tag_of(offs[i]), rdata_o, exp_read(offs[i]));
    end
    chk("R8 tx_irq", {7'b0, tx_irq_no}, {7'b0, ~|(m_tx & m_txm)});
    chk("R8 rx_irq", {7'b0, rx_irq_no}, {7'b0, ~|(m_rx & m_rxm)});
    chk("R9 core_rst", {7'b0, core_rst_o}, {7'b0, m_ctl[7]});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    // R1 reset state
    @(negedge clk_i); addr_i = 5'h13; #0.5;
    chk("R1 summary", rdata_o, 8'h03);
    chk("R1 irq/rst", {5'b0, tx_irq_no, rx_irq_no, core_rst_o}, 8'h06);
    check_all();

    // R2/R3 sticky, reserved rx bits pulsed
    cyc(0, 5'h00, 0, 8'h81, 8'h60);
    cyc(0, 5'h00, 0, 8'h00, 8'h11);
    check_all();
    chk("R3 reserved", m_rx & 8'h60, 8'h00);

    // R4 write-one-to-clear
    cyc(1, 5'h00, 8'h01, 0, 0);
    @(negedge clk_i); addr_i = 5'h00; #0.5;
    chk("R4 tx clear", rdata_o, 8'h80);
    cyc(1, 5'h02, 8'h10, 0, 0);
    @(negedge clk_i); addr_i = 5'h02; #0.5;
    chk("R4 rx clear", rdata_o, 8'h01);

    // R5 set beats clear
    cyc(1, 5'h00, 8'h84, 8'h04, 0);
    @(negedge clk_i); addr_i = 5'h00; #0.5;
    chk("R5 set wins", rdata_o, 8'h04);

    // R6 carrier live, write and event on bit 6 ignored
    carrier_i = 1;
    cyc(1, 5'h00, 8'h40, 8'h40, 0);
    @(negedge clk_i); addr_i = 5'h00; #0.5;
    chk("R6 carrier hi", rdata_o, 8'h44);
    carrier_i = 0; #0.5;
    chk("R6 carrier lo", rdata_o, 8'h04);

    // R7/R8 masks and interrupts
    cyc(1, 5'h01, 8'hFF, 0, 0);
    cyc(1, 5'h03, 8'hFF, 0, 0);
    check_all();
    // R10/R8 writes to summary and unmapped offsets
    cyc(1, 5'h13, 8'hFF, 0, 0);
    cyc(1, 5'h1F, 8'hFF, 0, 0);
    cyc(1, 5'h06, 8'hFF, 0, 0);
    check_all();

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      logic [2:0] sel;
      sel = 3'($urandom_range(0, 7));
      case (sel)
        0: a = 5'h00; 1: a = 5'h01; 2: a = 5'h02; 3: a = 5'h03;
        4: a = 5'h06; 5: a = 5'h13; default: a = 5'($urandom);
      endcase
      carrier_i = 1'($urandom);
      cyc(1'($urandom), a, 8'($urandom),
          ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00,
          ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00);
      if (n % 4 == 0) check_all();
    end
    check_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule